// File: doc/BRIEF.md
# Bit Count and Pack Unit

This block is the execute-stage datapath for a group of 64-bit bit-manipulation operations. It counts zero bits from either end of an operand, and it assembles a result from fixed slices of two operands in three different layouts. A 3-bit operation code selects the function. The two source operands are called `src_a` and `src_b`.

The arithmetic is purely combinational. A generate-selected output stage then either registers the result, so it appears one cycle after an accepted request, or passes it straight through. In the registered form, `in_valid` marks a request and `out_valid` marks the cycle in which its result is present. The result register loads only on a valid request. Between requests it keeps its last value.

Top module: `bcp_unit`

## Requirements
- R1: Operation code 0 returns the number of zero bits above the most significant set bit of `src_a`. An all-zero `src_a` gives 64.
- R2: Operation code 1 returns the number of zero bits below the least significant set bit of `src_a`. An all-zero `src_a` gives 64.
- R3: Operation code 2 returns `src_b[31:0]` in result bits [63:32] and `src_a[31:0]` in bits [31:0].
- R4: Operation code 3 returns `src_a[63:32]` in result bits [31:0] and `src_b[63:32]` in bits [63:32].
- R5: Operation code 4 returns `src_a[7:0]` in bits [7:0] and `src_b[7:0]` in bits [15:8]. Bits [63:16] are zero.
- R6: Operation codes 5, 6 and 7 return an all-zero result.
- R7: Count results (codes 0 and 1) are zero-extended to 64 bits and never exceed 64. Bits [63:7] are always zero.
- R8: With the output register enabled, the result for a request accepted on one rising edge is visible after that edge. `out_valid` is high exactly in the cycle that follows a cycle with `in_valid` high.
- R9: While `rst` is high, at a rising edge `out_valid` and `result` are cleared to zero.
- R10: When `in_valid` is low, `result` keeps its previous value whatever the operands and operation code are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| op_sel | input | 3 | Operation code (0..4 defined, 5..7 give zero) |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Operation result |

## Verification
Counts at the extremes are the hardest outcomes to reach with random operands. These are 63 and 64, where only the last bit or no bit at all is set. Random 64-bit values almost never have more than a few leading or trailing zeros. The stimulus therefore adds directed all-zero and all-ones operands and single-bit walks across both ends. It also uses random values masked by a random-length shift, so that count values spread across the whole range. Idle cycles carrying scrambled operands confirm that the held result does not move.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        OP_CLZ   = 3'd0,
        OP_CTZ   = 3'd1,
        OP_PACK  = 3'd2,
        OP_PACKU = 3'd3,
        OP_PACKH = 3'd4
    } bcp_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] pack_lo;
        logic [DATA_W-1:0] pack_hi;
        logic [DATA_W-1:0] pack_byte;
    } bcp_pack_t;

    function automatic logic [DATA_W-1:0] widen_count(input logic [CNT_W-1:0] c);
        return {{(DATA_W-CNT_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/bcp_zero_count.sv
module bcp_zero_count #(
    parameter int W       = 64,
    parameter bit LEADING = 1'b0,
    localparam int CW     = $clog2(W + 1)
) (
    input  logic [W-1:0]  value,
    output logic [CW-1:0] count
);

    logic [W-1:0] scan;

    generate
        if (LEADING) begin : g_rev
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign scan[i] = value[W-1-i];
            end
        end else begin : g_fwd
            assign scan = value;
        end
    endgenerate

    // lowest set index of scan; W when none is set
    always_comb begin
        count = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (scan[i]) count = CW'(i);
        end
    end

endmodule

// File: rtl/bcp_packer.sv
module bcp_packer
    import bcp_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output bcp_pack_t         packs
);

    always_comb begin
        packs.pack_lo   = {b[HALF_W-1:0], a[HALF_W-1:0]};
        packs.pack_hi   = {b[DATA_W-1:HALF_W], a[DATA_W-1:HALF_W]};
        packs.pack_byte = '0;
        packs.pack_byte[2*BYTE_W-1:0] = {b[BYTE_W-1:0], a[BYTE_W-1:0]};
    end

endmodule

// File: rtl/bcp_unit.sv
module bcp_unit
    import bcp_pkg::*;
#(
    parameter bit PIPE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    logic [CNT_W-1:0]  lead_cnt;
    logic [CNT_W-1:0]  trail_cnt;
    bcp_pack_t         packs;
    logic [DATA_W-1:0] comb_res;

    bcp_zero_count #(.W(DATA_W), .LEADING(1'b1)) u_lead (
        .value (src_a),
        .count (lead_cnt)
    );

    bcp_zero_count #(.W(DATA_W), .LEADING(1'b0)) u_trail (
        .value (src_a),
        .count (trail_cnt)
    );

    bcp_packer u_pack (
        .a     (src_a),
        .b     (src_b),
        .packs (packs)
    );

    always_comb begin
        case (bcp_op_e'(op_sel))
            OP_CLZ:   comb_res = widen_count(lead_cnt);
            OP_CTZ:   comb_res = widen_count(trail_cnt);
            OP_PACK:  comb_res = packs.pack_lo;
            OP_PACKU: comb_res = packs.pack_hi;
            OP_PACKH: comb_res = packs.pack_byte;
            default:  comb_res = '0;
        endcase
    end

    generate
        if (PIPE) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    result    <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) result <= comb_res;
                end
            end
        end else begin : g_comb
            assign out_valid = in_valid;
            assign result    = comb_res;
        end
    endgenerate

endmodule

// File: rtl/bcp_unit_chk.sv
module bcp_unit_chk
    import bcp_pkg::*;
#(
    parameter bit PIPE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    generate
        if (PIPE) begin : g_chk
            assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            assert_idle_follows_R8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            assert_count_bounded_R7: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel <= 3'd1) |=> (result[DATA_W-1:CNT_W] == '0 && result <= DATA_W));
            assert_pack_low_R3: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 3'd2) |=> (result[HALF_W-1:0] == $past(src_a[HALF_W-1:0])));
            assert_pack_high_R4: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 3'd3) |=> (result[DATA_W-1:HALF_W] == $past(src_b[DATA_W-1:HALF_W])));
            assert_byte_pack_R5: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 3'd4) |=>
                    (result[DATA_W-1:16] == '0 && result[7:0] == $past(src_a[7:0])));
            assert_unused_code_R6: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel > 3'd4) |=> (result == '0));
            assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(result));
        end
    endgenerate

endmodule

bind bcp_unit bcp_unit_chk #(.PIPE(PIPE)) u_bcp_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_bcp_unit.sv
module tb_bcp_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bcp_unit dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [63:0] ref_model(input logic [2:0] op, input logic [63:0] a,
                                              input logic [63:0] b);
        logic [63:0] r;
        int n;
        r = '0;
        case (op)
            3'd0: begin
                n = 0;
                while (n < 64 && a[63-n] == 1'b0) n++;
                r = 64'(n);
            end
            3'd1: begin
                n = 0;
                while (n < 64 && a[n] == 1'b0) n++;
                r = 64'(n);
            end
            3'd2: r = {b[31:0], a[31:0]};
            3'd3: r = {b[63:32], a[63:32]};
            3'd4: r = {48'd0, b[7:0], a[7:0]};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, captured at next posedge, checked at the following negedge
    task automatic run_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp;
        exp = ref_model(op, a, b);
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = op;
        src_a    = a;
        src_b    = b;
        @(negedge clk);
        check(req_of(op), result, exp);
        check("R8", 64'(out_valid), 64'd1);
        if (op <= 3'd1) check("R7", 64'(result > 64 || result[63:7] != 0), 64'd0);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [63:0] held;
        logic [63:0] ra;
        logic [63:0] rb;
        void'($urandom(32'd2024));

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", result, 64'd0);
        check("R9", 64'(out_valid), 64'd0);
        rst = 1'b0;

        // directed corners: all zeros, all ones for every code
        for (int op = 0; op < 8; op++) begin
            run_op(3'(op), 64'd0, 64'd0);
            run_op(3'(op), '1, '1);
            run_op(3'(op), 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        end

        // single-bit walks for both counts (R1, R2)
        for (int i = 0; i < 64; i++) begin
            run_op(3'd0, 64'd1 << i, 64'd0);
            run_op(3'd1, 64'd1 << i, 64'd0);
        end

        // random operands, count spread via random masks
        for (int k = 0; k < 300; k++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (k % 3 == 0) ra = ra >> ($urandom % 64);
            if (k % 3 == 1) ra = ra << ($urandom % 64);
            run_op(3'($urandom % 8), ra, rb);
        end

        // R8: out_valid drops the cycle after in_valid drops
        run_op(3'd2, 64'hAAAA_5555_1234_5678, 64'h9999_0000_FFFF_1111);
        held = result;
        @(negedge clk);
        check("R8", 64'(out_valid), 64'd0);

        // R10: idle cycles with scrambled inputs leave result untouched
        for (int k = 0; k < 10; k++) begin
            op_sel = 3'($urandom % 5);
            src_a  = {$urandom, $urandom};
            src_b  = {$urandom, $urandom};
            @(negedge clk);
            check("R10", result, held);
        end

        // R9: reset after activity clears state
        run_op(3'd3, '1, '1);
        rst = 1'b1;
        @(negedge clk);
        check("R9", result, 64'd0);
        check("R9", 64'(out_valid), 64'd0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule